// File: doc/BRIEF.md
# Converter Fault Supervisor with Auto-Restart

This block sits between the comparators of a single-stage switching LED converter and its gate and clamp drivers. It watches supply-level flags, the protection comparators of the power stage, the activity of an active voltage clamp and a die-temperature flag. From these it decides, every clock, whether the power switch may run and whether the clamp may run. It also reports the fault of highest priority as a 3-bit code.

Each class of fault has its own way back to normal operation. Output overvoltage, overcurrent and a sense level that never reaches its minimum all lead to a short timed wait, nominally one second. A power-switch overpower fault leads to a long timed wait, nominally thirty seconds. If the clamp is on too much of the time, the stage stays latched off until the supply is cycled. Die overtemperature holds the stage off until a separate cool-down flag reports that the temperature has fallen by the hysteresis margin. The block averages clamp activity itself and leaves every other comparison to the analog front end. A millisecond tick paces the waits.

Top module: `fault_supervisor`

## Requirements
- R1: The block is powered after a clock in which `vdd_rise` is high, and unpowered after a clock in which `vdd_fall` is high (`vdd_fall` wins if both are high); it is unpowered after reset. While unpowered, `sw_en` and `clamp_en` are 0 and `fault_code` is 1.
- R2: While powered and no timed wait is running, a clock with `ovp_flag`, `ocp_flag` or `low_peak_flag` high (and `sop_flag` low) starts a short wait of SHORT_MS ticks. During the wait `sw_en` is 0 and `fault_code` is 5, and `sw_en` returns in the cycle after the SHORT_MS-th tick.
- R3: While powered and no timed wait is running, a clock with `sop_flag` high starts a long wait of LONG_MS ticks, reported as `fault_code` 4, with the same release rule as R2.
- R4: Fault flags seen while a wait is running neither restart nor lengthen it.
- R5: When `sop_flag` and a short-wait flag are high in the same clock, the long wait is chosen.
- R6: The clamp average A (AVG_W bits, reset 0) is updated each powered clock: A + ((2^AVG_W-1-A) >> AVG_SHIFT) when `clamp_on` is 1, and A - (A >> AVG_SHIFT) when it is 0. After a clock in which A > floor((2^AVG_W-1)*LIMIT_PCT/100), the latched clamp fault is set. It forces `sw_en` and `clamp_en` to 0 and reports `fault_code` 2 until the block is unpowered.
- R7: A clock with `die_hot` high sets the thermal hold: `sw_en` is 0 and `fault_code` is 3. The hold is cleared only by a clock with `die_cool` high and `die_hot` low.
- R8: `fault_code` follows this priority: unpowered 1, clamp latch 2, thermal hold 3, long wait 4, short wait 5, and otherwise 0 with `sw_en` 1.
- R9: Becoming unpowered clears the clamp latch, the clamp average, any wait and the thermal hold, so that on the next power-up the stage runs at once.
- R10: Waits advance only on clocks with `ms_tick` high; without ticks a wait never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vdd_rise | input | 1 | Supply above turn-on level |
| vdd_fall | input | 1 | Supply below turn-off level |
| ovp_flag | input | 1 | Output overvoltage comparator |
| ocp_flag | input | 1 | Switch overcurrent comparator |
| low_peak_flag | input | 1 | Sensed current missed its minimum level |
| sop_flag | input | 1 | Power-switch overpower |
| clamp_on | input | 1 | Clamp conducting this clock |
| die_hot | input | 1 | Die above shutdown temperature |
| die_cool | input | 1 | Die below release temperature |
| ms_tick | input | 1 | One-millisecond pulse |
| sw_en | output | 1 | Power switch may run |
| clamp_en | output | 1 | Clamp may run |
| fault_code | output | 3 | Highest-priority fault (R8) |

## Verification
The hardest state to reach from the ports is the clamp latch near its limit. The average is hidden, and whether it crosses depends on the exact run of clamp pulses and on the rounding of each step. The bench drives directed bursts, one just below and one just over the limit, starting from a known residue. Random clamp activity is mixed with power drops, which reset the average. A cycle model of the average and the timers predicts the outputs on every clock.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_UVLO  = 3'd1,
    FC_CLAMP = 3'd2,
    FC_THERM = 3'd3,
    FC_SLOW  = 3'd4,
    FC_FAST  = 3'd5
  } fault_code_e;

  // one step of the first-order clamp-activity filter
  function automatic logic [31:0] iir_step(input logic [31:0] acc, input logic on,
                                           input logic [31:0] full, input int unsigned shift);
    if (on) return acc + ((full - acc) >> shift);
    else    return acc - (acc >> shift);
  endfunction

  // integer fraction of full scale used as the clamp duty limit
  function automatic logic [31:0] duty_limit(input logic [31:0] full, input int unsigned pct);
    return (full * pct) / 32'd100;
  endfunction

endpackage

// File: rtl/uvlo_gate.sv
module uvlo_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_flag,
  input  logic fall_flag,
  output logic powered
);
  logic pow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pow_q <= 1'b0;
    else if (pow_q && fall_flag)    pow_q <= 1'b0;
    else if (!pow_q && rise_flag && !fall_flag) pow_q <= 1'b1;
  end

  assign powered = pow_q;

  assert_fall_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_flag |=> !powered);
endmodule

// File: rtl/retry_timer.sv
module retry_timer #(
  parameter int unsigned SHORT_MS = 1000,
  parameter int unsigned LONG_MS  = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic short_req,
  input  logic long_req,
  input  logic tick,
  output logic busy,
  output logic is_long
);
  localparam int unsigned CNT_W = $clog2(LONG_MS + 1);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_MS);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_MS);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic             load_long, load_short;

  assign busy       = (cnt_q != '0);
  assign load_long  = !busy && long_req;
  assign load_short = !busy && short_req && !long_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (load_long) begin
      cnt_q  <= LONG_V;
      long_q <= 1'b1;
    end else if (load_short) begin
      cnt_q  <= SHORT_V;
      long_q <= 1'b0;
    end else if (busy && tick) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign is_long = long_q;

  assert_short_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_short) |=> (cnt_q == SHORT_V && !is_long));
  assert_long_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_long) |=> (cnt_q == LONG_V && is_long));
  assert_no_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && busy) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && busy && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/clamp_duty_avg.sv
module clamp_duty_avg
  import fault_sup_pkg::*;
#(
  parameter int unsigned AVG_W     = 16,
  parameter int unsigned AVG_SHIFT = 6,
  parameter int unsigned LIMIT_PCT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic clamp_on,
  output logic latched
);
  localparam logic [31:0] FULL = 32'((64'd1 << AVG_W) - 64'd1);
  localparam logic [AVG_W-1:0] LIMIT = AVG_W'(duty_limit(FULL, LIMIT_PCT));

  logic [AVG_W-1:0] avg_q;
  logic             latch_q;
  logic             over_evt;

  assign over_evt = (avg_q > LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q   <= '0;
      latch_q <= 1'b0;
    end else if (clear) begin
      avg_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      avg_q <= AVG_W'(iir_step(32'(avg_q), clamp_on, FULL, AVG_SHIFT));
      if (over_evt) latch_q <= 1'b1;
    end
  end

  assign latched = latch_q;

  assert_over_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && over_evt) |=> latched);
  assert_latch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && latched) |=> latched);
  assert_idle_decays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !clamp_on) |=> (avg_q <= $past(avg_q)));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int unsigned SHORT_MS  = 1000,
  parameter int unsigned LONG_MS   = 30000,
  parameter int unsigned AVG_W     = 16,
  parameter int unsigned AVG_SHIFT = 6,
  parameter int unsigned LIMIT_PCT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vdd_rise,
  input  logic       vdd_fall,
  input  logic       ovp_flag,
  input  logic       ocp_flag,
  input  logic       low_peak_flag,
  input  logic       sop_flag,
  input  logic       clamp_on,
  input  logic       die_hot,
  input  logic       die_cool,
  input  logic       ms_tick,
  output logic       sw_en,
  output logic       clamp_en,
  output logic [2:0] fault_code
);
  logic powered, power_clear;
  logic wait_busy, wait_long;
  logic clamp_latched;
  logic short_fault;
  logic therm_q;
  fault_code_e code_w;

  uvlo_gate u_uvlo (
    .clk(clk), .rst_n(rst_n), .rise_flag(vdd_rise), .fall_flag(vdd_fall), .powered(powered)
  );

  assign power_clear = !powered;
  assign short_fault = ovp_flag | ocp_flag | low_peak_flag;

  retry_timer #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(power_clear), .short_req(short_fault),
    .long_req(sop_flag), .tick(ms_tick), .busy(wait_busy), .is_long(wait_long)
  );

  clamp_duty_avg #(.AVG_W(AVG_W), .AVG_SHIFT(AVG_SHIFT), .LIMIT_PCT(LIMIT_PCT)) u_clamp (
    .clk(clk), .rst_n(rst_n), .clear(power_clear), .clamp_on(clamp_on), .latched(clamp_latched)
  );

  // thermal hold with release on the separate cool-down flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           therm_q <= 1'b0;
    else if (power_clear) therm_q <= 1'b0;
    else if (die_hot)     therm_q <= 1'b1;
    else if (die_cool)    therm_q <= 1'b0;
  end

  always_comb begin
    if (!powered)           code_w = FC_UVLO;
    else if (clamp_latched) code_w = FC_CLAMP;
    else if (therm_q)       code_w = FC_THERM;
    else if (wait_busy)     code_w = wait_long ? FC_SLOW : FC_FAST;
    else                    code_w = FC_NONE;
  end

  assign fault_code = code_w;
  assign sw_en      = powered && !clamp_latched && !therm_q && !wait_busy;
  assign clamp_en   = powered && !clamp_latched;

  assert_unpowered_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |-> (!sw_en && !clamp_en && fault_code == 3'd1));
  assert_wait_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wait_busy |-> !sw_en);
  assert_latch_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_latched |-> (!sw_en && !clamp_en));
  assert_hold_until_cool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && therm_q && !die_cool) |=> (therm_q || !powered));
  assert_latch_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && clamp_latched) |-> fault_code == 3'd2);
  assert_drop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |=> (!clamp_latched && !therm_q && !wait_busy));
endmodule

// File: tb/fault_supervisor_tb.sv
module fault_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_MS   = 12;
  localparam int LONG_MS    = 40;
  localparam int AVG_W      = 12;
  localparam int AVG_SHIFT  = 5;
  localparam int LIMIT_PCT  = 10;
  localparam longint FULLV  = (64'd1 << AVG_W) - 1;
  localparam longint LIMV   = FULLV * LIMIT_PCT / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vdd_rise = 0, vdd_fall = 0, ovp_flag = 0, ocp_flag = 0, low_peak_flag = 0;
  logic sop_flag = 0, clamp_on = 0, die_hot = 0, die_cool = 0, ms_tick = 0;
  logic sw_en, clamp_en;
  logic [2:0] fault_code;

  int checks = 0;
  int errors = 0;

  fault_supervisor #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS), .AVG_W(AVG_W),
                     .AVG_SHIFT(AVG_SHIFT), .LIMIT_PCT(LIMIT_PCT)) u_dut (
    .clk(clk), .rst_n(rst_n), .vdd_rise(vdd_rise), .vdd_fall(vdd_fall),
    .ovp_flag(ovp_flag), .ocp_flag(ocp_flag), .low_peak_flag(low_peak_flag),
    .sop_flag(sop_flag), .clamp_on(clamp_on), .die_hot(die_hot), .die_cool(die_cool),
    .ms_tick(ms_tick), .sw_en(sw_en), .clamp_en(clamp_en), .fault_code(fault_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state, built from the requirement text
  bit     m_pow, m_long, m_hold, m_latch;
  int     m_wait;
  longint m_avg;

  function automatic longint avg_next(longint a, bit on);
    if (on) return a + (FULLV - a) / (64'd1 << AVG_SHIFT);
    return a - a / (64'd1 << AVG_SHIFT);
  endfunction

  function automatic int exp_code();
    if (!m_pow)  return 1;
    if (m_latch) return 2;
    if (m_hold)  return 3;
    if (m_wait != 0) return m_long ? 4 : 5;
    return 0;
  endfunction

  function automatic string code_tag(int c);
    case (c)
      0: return "R8";
      1: return "R1";
      2: return "R6";
      3: return "R7";
      4: return "R3";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pow = 0; m_long = 0; m_hold = 0; m_latch = 0; m_wait = 0; m_avg = 0;
    end else begin
      bit np;
      np = m_pow ? !vdd_fall : (vdd_rise && !vdd_fall);
      if (!m_pow) begin
        m_wait = 0; m_long = 0; m_hold = 0; m_latch = 0; m_avg = 0;
      end else begin
        if (m_avg > LIMV) m_latch = 1;
        m_avg = avg_next(m_avg, clamp_on);
        if (m_wait == 0) begin
          if (sop_flag) begin m_wait = LONG_MS; m_long = 1; end
          else if (ovp_flag || ocp_flag || low_peak_flag) begin m_wait = SHORT_MS; m_long = 0; end
        end else if (ms_tick) m_wait = m_wait - 1;
        if (die_hot) m_hold = 1;
        else if (die_cool) m_hold = 0;
      end
      m_pow = np;
    end
  end

  task automatic check(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic compare_model();
    int ec;
    ec = exp_code();
    check(code_tag(ec), "fault_code", int'(fault_code), ec);
    check(code_tag(ec), "sw_en", int'(sw_en), (ec == 0) ? 1 : 0);
    check(code_tag(ec), "clamp_en", int'(clamp_en), (ec == 0 || ec >= 3) ? 1 : 0);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_model();
    end
  endtask

  task automatic quiet();
    vdd_rise = 0; vdd_fall = 0; ovp_flag = 0; ocp_flag = 0; low_peak_flag = 0;
    sop_flag = 0; clamp_on = 0; die_hot = 0; die_cool = 0; ms_tick = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    // reset state (R1)
    repeat (3) @(negedge clk);
    check("R1", "reset sw_en", int'(sw_en), 0);
    check("R1", "reset clamp_en", int'(clamp_en), 0);
    check("R1", "reset code", int'(fault_code), 1);
    rst_n = 1'b1;
    cyc(4);
    check("R1", "no rise stays off", int'(fault_code), 1);
    vdd_rise = 1; cyc(); vdd_rise = 0; cyc();
    check("R1", "powered runs", int'(sw_en), 1);

    // short wait, tick dependence (R2, R10)
    ovp_flag = 1; cyc(); ovp_flag = 0;
    check("R2", "ovp short code", int'(fault_code), 5);
    cyc(30);
    check("R10", "no ticks keeps wait", int'(sw_en), 0);
    ms_tick = 1; cyc(SHORT_MS - 1);
    check("R2", "wait not yet over", int'(sw_en), 0);
    cyc(); ms_tick = 0;
    check("R2", "released after SHORT_MS ticks", int'(sw_en), 1);

    // long wait chosen over short, re-trigger ignored (R5, R4, R3)
    sop_flag = 1; ocp_flag = 1; cyc(); sop_flag = 0; ocp_flag = 0;
    check("R5", "simultaneous picks long", int'(fault_code), 4);
    ms_tick = 1; cyc(LONG_MS / 2);
    low_peak_flag = 1; sop_flag = 1; cyc(); low_peak_flag = 0; sop_flag = 0;
    cyc(LONG_MS - LONG_MS / 2 - 2);
    check("R4", "retrigger not restarting", int'(fault_code), 4);
    cyc(); ms_tick = 0;
    check("R3", "long wait released", int'(sw_en), 1);

    // thermal hold (R7) and priority over a wait (R8)
    die_hot = 1; low_peak_flag = 1; cyc(); die_hot = 0; low_peak_flag = 0;
    check("R8", "thermal over short wait", int'(fault_code), 3);
    cyc(10);
    check("R7", "hold without cool", int'(fault_code), 3);
    check("R7", "clamp runs in thermal hold", int'(clamp_en), 1);
    die_cool = 1; cyc(); die_cool = 0;
    check("R8", "short wait shows after thermal", int'(fault_code), 5);
    ms_tick = 1; cyc(SHORT_MS); ms_tick = 0;
    check("R7", "all clear", int'(sw_en), 1);

    // clamp average: three pulses stay below the limit, four cross it (R6)
    clamp_on = 1; cyc(3); clamp_on = 0; cyc(5);
    check("R6", "three pulses below limit", int'(fault_code), 0);
    cyc(200);
    clamp_on = 1; cyc(4); clamp_on = 0; cyc(2);
    check("R6", "four pulses latch", int'(fault_code), 2);
    check("R6", "clamp disabled", int'(clamp_en), 0);
    die_hot = 1; sop_flag = 1; cyc(); die_hot = 0; sop_flag = 0; cyc(3);
    check("R8", "latch outranks others", int'(fault_code), 2);
    die_cool = 1; ms_tick = 1; cyc(LONG_MS + 2); die_cool = 0; ms_tick = 0;
    check("R6", "latch survives waits", int'(sw_en), 0);

    // power cycle clears the latch (R9)
    vdd_fall = 1; cyc(); vdd_fall = 0;
    check("R1", "fall unpowers", int'(fault_code), 1);
    cyc(3);
    vdd_rise = 1; cyc(); vdd_rise = 0;
    check("R9", "runs after power cycle", int'(sw_en), 1);
    check("R9", "clamp back after power cycle", int'(clamp_en), 1);
    vdd_rise = 1; vdd_fall = 1; cyc(); quiet();
    check("R1", "fall wins over rise", int'(fault_code), 1);

    // constrained random phase
    for (int i = 0; i < 40000; i++) begin
      int burst;
      burst = (i / 2000) % 3;
      vdd_rise      = ($urandom % 20) == 0;
      vdd_fall      = ($urandom % 1500) == 0;
      ovp_flag      = ($urandom % 300) == 0;
      ocp_flag      = ($urandom % 300) == 0;
      low_peak_flag = ($urandom % 300) == 0;
      sop_flag      = ($urandom % 900) == 0;
      die_hot       = ($urandom % 700) == 0;
      die_cool      = ($urandom % 40) == 0;
      ms_tick       = ($urandom % 2) == 0;
      clamp_on      = (burst == 2) ? (($urandom % 4) == 0) : (($urandom % 60) == 0);
      cyc();
    end
    quiet();
    cyc(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule